// File: doc/BRIEF.md
# Keyed Configuration Port Controller

This block is a two-address configuration port: one address acts as an index port and the next address up acts as a data port. A host write to the index port chooses an internal register. A later read or write at the data port then reaches that register. Both ports stay closed until the host writes an opening key to the index port twice in a row. A closing key written to the index port shuts them again. While the ports are closed, data-port writes have no effect and every read returns all ones.

The controller holds the global identification registers and four pin-multiplexing byte registers, which it exports to the pad logic. It also holds a logical-device number. For one logical device of its own, it keeps the activation bit and the 16-bit base address. A data-port access at index 0x30 or above that the block does not hold is sent out on a single-cycle strobe bus. That bus carries the logical-device number and the index, so the devices behind the port can decode the access. A strap input, sampled while reset is asserted, chooses which of two port base addresses is decoded.

Top module: `cfg_port_top`

## Requirements
- R1: The ports open only after two consecutive index-port writes of 0x87 while closed.
- R2: While closed, an index-port write of any value other than 0x87 cancels a half-entered key, so two further 0x87 writes are needed.
- R3: While open, an index-port write of 0xAA closes the ports; any other index-port value is latched as the current index.
- R4: While closed, data-port writes change no register. Data-port and index-port reads return 0xFF.
- R5: With the strap low during reset, the index port is 0x2E and the data port is 0x2F. With the strap high, they are 0x4E and 0x4F. Accesses to any other address have no effect.
- R6: The identification bytes are read-only, and writes to them are ignored: device ID high at 0x20, device ID low at 0x21, revision at 0x22, manufacturer ID high at 0x23, manufacturer ID low at 0x24.
- R7: Register 0x07 holds the logical-device number, which can be read and written. A read of the index port while open returns the latched index.
- R8: Registers 0x27, 0x29, 0x2A and 0x2B are full-byte read/write. They appear on `pinMuxCfg` as byte 0 (bits 7:0), byte 1, byte 2 and byte 3, in that order.
- R9: When the logical-device number equals OWN_LDN (default 7), the block itself handles three registers. At 0x30, bit 0 is the device activation and reads back with bits 7:1 as zero. At 0x60 and 0x61 are the high and low bytes of the device base address. These drive `ldEnable` and `ldBase`.
- R10: Any other open data-port access at index 0x30 or above raises `devWr` or `devRd` in the same cycle, for one cycle, with `devLdn`, `devIdx` and `devWrData` valid. A read returns the `devRdData` value present in that cycle.
- R11: Indexes below 0x30 that are not listed above read 0x00 and ignore writes.
- R12: Read data appears on `busRdData` in the cycle after the read strobe and holds until the next port read. After reset, all held registers and `busRdData` are zero and the ports are closed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| strapAlt | input | 1 | Base-address strap, sampled during reset |
| busAddr | input | 16 | Host I/O address |
| busWr | input | 1 | Host write strobe |
| busRd | input | 1 | Host read strobe |
| busWrData | input | 8 | Host write data |
| busRdData | output | 8 | Host read data (registered) |
| pinMuxCfg | output | 32 | Pin-mux register bytes |
| ldEnable | output | 1 | Activation bit of the held logical device |
| ldBase | output | 16 | Base address of the held logical device |
| devWr | output | 1 | Device register write strobe |
| devRd | output | 1 | Device register read strobe |
| devLdn | output | 8 | Logical-device number for the strobe |
| devIdx | output | 8 | Register index for the strobe |
| devWrData | output | 8 | Write data for the strobe |
| devRdData | input | 8 | Read data returned by the selected device |

## Verification
The bench goes after the key sequence. It checks a single 0x87 followed by a stray value: a design that counted keys without restarting would open on the next 0x87. It also checks that locked data writes really leave the mux bytes untouched, since a design that gated only reads would corrupt pad configuration. For the registers held for OWN_LDN, it switches the device number away and confirms that the same index then goes to the strobe bus; a design that decoded the index alone would write its own activation bit instead. Finally, it resets with the strap high, where a design with a hard-wired base address would ignore every access at 0x4E.

// File: rtl/cfgport_pkg.sv
package cfgport_pkg;
  typedef enum logic [1:0] {
    KS_LOCKED = 2'd0,
    KS_HALF   = 2'd1,
    KS_OPEN   = 2'd2
  } keyState_t;

  typedef struct packed {
    logic idxWr;
    logic dataWr;
    logic dataRd;
    logic idxRd;
    logic open;
  } cfgStrobe_t;

  localparam logic [7:0] KEY_OPEN  = 8'h87;
  localparam logic [7:0] KEY_CLOSE = 8'hAA;

  localparam logic [7:0] IX_LDN     = 8'h07;
  localparam logic [7:0] IX_DEVID_H = 8'h20;
  localparam logic [7:0] IX_DEVID_L = 8'h21;
  localparam logic [7:0] IX_REV     = 8'h22;
  localparam logic [7:0] IX_MANID_H = 8'h23;
  localparam logic [7:0] IX_MANID_L = 8'h24;
  localparam logic [7:0] IX_ACT     = 8'h30;
  localparam logic [7:0] IX_BASE_H  = 8'h60;
  localparam logic [7:0] IX_BASE_L  = 8'h61;
  localparam logic [7:0] IX_DEVFIRST = 8'h30;
endpackage

// File: rtl/cfg_port_ctl.sv
module cfg_port_ctl
  import cfgport_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE_PRI = 16'h002E,
  parameter logic [ADDR_W-1:0] BASE_ALT = 16'h004E
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              strapAlt,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [7:0]        busWrData,
  output cfgStrobe_t        stb
);
  logic altSel;
  logic [ADDR_W-1:0] idxAddr;
  logic [ADDR_W-1:0] dataAddr;
  logic hitIdx;
  logic hitData;
  logic idxWrAny;
  keyState_t keyState;
  keyState_t keyNext;

  // strap captured while reset is held
  always_ff @(posedge clk) begin
    if (!rstN) altSel <= strapAlt;
  end

  assign idxAddr  = altSel ? BASE_ALT : BASE_PRI;
  assign dataAddr = idxAddr + ADDR_W'(1);
  assign hitIdx   = (busAddr == idxAddr);
  assign hitData  = (busAddr == dataAddr);
  assign idxWrAny = busWr && hitIdx;

  always_comb begin
    keyNext = keyState;
    if (idxWrAny) begin
      unique case (keyState)
        KS_LOCKED: keyNext = (busWrData == KEY_OPEN) ? KS_HALF : KS_LOCKED;
        KS_HALF:   keyNext = (busWrData == KEY_OPEN) ? KS_OPEN : KS_LOCKED;
        KS_OPEN:   keyNext = (busWrData == KEY_CLOSE) ? KS_LOCKED : KS_OPEN;
        default:   keyNext = KS_LOCKED;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) keyState <= KS_LOCKED;
    else       keyState <= keyNext;
  end

  always_comb begin
    stb.open   = (keyState == KS_OPEN);
    stb.idxWr  = idxWrAny && stb.open && (busWrData != KEY_CLOSE);
    stb.dataWr = busWr && hitData && stb.open;
    stb.dataRd = busRd && hitData;
    stb.idxRd  = busRd && hitIdx;
  end

  // R1: opening is always preceded by an index write of the key
  assert_open_after_key_R1: assert property (@(posedge clk) disable iff (!rstN)
    (stb.open && !$past(stb.open)) |-> $past(idxWrAny && busWrData == KEY_OPEN && keyState == KS_HALF));

  // R2: a stray index value while half-entered drops back to locked
  assert_key_restart_R2: assert property (@(posedge clk) disable iff (!rstN)
    (keyState == KS_HALF && idxWrAny && busWrData != KEY_OPEN) |=> (keyState == KS_LOCKED));

  // R3: the closing key shuts the ports
  assert_close_key_R3: assert property (@(posedge clk) disable iff (!rstN)
    (stb.open && idxWrAny && busWrData == KEY_CLOSE) |=> !stb.open);
endmodule

// File: rtl/cfg_port_dp.sv
module cfg_port_dp
  import cfgport_pkg::*;
#(
  parameter logic [15:0] DEV_ID  = 16'h5A31,
  parameter logic [7:0]  DEV_REV = 8'h04,
  parameter logic [15:0] MAN_ID  = 16'h3C29,
  parameter logic [7:0]  OWN_LDN = 8'h07,
  parameter int          MUX_N   = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  cfgStrobe_t         stb,
  input  logic [7:0]         busWrData,
  output logic [7:0]         busRdData,
  output logic [8*MUX_N-1:0] pinMuxCfg,
  output logic               ldEnable,
  output logic [15:0]        ldBase,
  output logic               devWr,
  output logic               devRd,
  output logic [7:0]         devLdn,
  output logic [7:0]         devIdx,
  output logic [7:0]         devWrData,
  input  logic [7:0]         devRdData
);
  localparam logic [7:0] MUX_IDX [4] = '{8'h27, 8'h29, 8'h2A, 8'h2B};

  logic [7:0] idxReg;
  logic [7:0] ldnReg;
  logic       actReg;
  logic [7:0] baseHi;
  logic [7:0] baseLo;
  logic [7:0] rdReg;
  logic [7:0] muxReg [MUX_N];
  logic [MUX_N-1:0] muxHit;
  logic ownLdn;
  logic heldHigh;
  logic routed;
  logic [7:0] regRd;
  logic [7:0] muxRd;

  assign ownLdn   = (ldnReg == OWN_LDN);
  assign heldHigh = ownLdn && (idxReg == IX_ACT || idxReg == IX_BASE_H || idxReg == IX_BASE_L);
  assign routed   = stb.open && (idxReg >= IX_DEVFIRST) && !heldHigh;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idxReg <= '0;
      ldnReg <= '0;
      actReg <= 1'b0;
      baseHi <= '0;
      baseLo <= '0;
    end else begin
      if (stb.idxWr) idxReg <= busWrData;
      if (stb.dataWr) begin
        if (idxReg == IX_LDN) ldnReg <= busWrData;
        if (ownLdn && idxReg == IX_ACT)    actReg <= busWrData[0];
        if (ownLdn && idxReg == IX_BASE_H) baseHi <= busWrData;
        if (ownLdn && idxReg == IX_BASE_L) baseLo <= busWrData;
      end
    end
  end

  for (genvar g = 0; g < MUX_N; g++) begin : gMux
    assign muxHit[g] = (idxReg == MUX_IDX[g]);
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                         muxReg[g] <= '0;
      else if (stb.dataWr && muxHit[g])  muxReg[g] <= busWrData;
    end
    assign pinMuxCfg[8*g +: 8] = muxReg[g];
  end

  always_comb begin
    muxRd = '0;
    for (int k = 0; k < MUX_N; k++)
      if (muxHit[k]) muxRd = muxReg[k];
  end

  always_comb begin
    regRd = 8'h00;
    if (routed) regRd = devRdData;
    else if (|muxHit) regRd = muxRd;
    else begin
      case (idxReg)
        IX_LDN:     regRd = ldnReg;
        IX_DEVID_H: regRd = DEV_ID[15:8];
        IX_DEVID_L: regRd = DEV_ID[7:0];
        IX_REV:     regRd = DEV_REV;
        IX_MANID_H: regRd = MAN_ID[15:8];
        IX_MANID_L: regRd = MAN_ID[7:0];
        IX_ACT:     regRd = heldHigh ? {7'd0, actReg} : 8'h00;
        IX_BASE_H:  regRd = heldHigh ? baseHi : 8'h00;
        IX_BASE_L:  regRd = heldHigh ? baseLo : 8'h00;
        default:    regRd = 8'h00;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdReg <= '0;
    else if (stb.dataRd) rdReg <= stb.open ? regRd : 8'hFF;
    else if (stb.idxRd)  rdReg <= stb.open ? idxReg : 8'hFF;
  end

  assign busRdData = rdReg;
  assign ldEnable  = actReg;
  assign ldBase    = {baseHi, baseLo};
  assign devWr     = stb.dataWr && routed;
  assign devRd     = stb.dataRd && routed;
  assign devLdn    = ldnReg;
  assign devIdx    = idxReg;
  assign devWrData = busWrData;

  // R4: closed ports leave every stored byte unchanged
  assert_locked_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    !stb.open |=> ($stable(pinMuxCfg) && $stable(ldBase) && $stable(ldEnable)));

  // R4: closed data reads return all ones
  assert_locked_read_R4: assert property (@(posedge clk) disable iff (!rstN)
    (stb.dataRd && !stb.open) |=> (busRdData == 8'hFF));

  // R10: device strobes only while open and never both
  assert_dev_strobe_R10: assert property (@(posedge clk) disable iff (!rstN)
    (devWr || devRd) |-> (stb.open && $onehot0({devWr, devRd})));

  // R12: read data moves only after a port read
  assert_rd_hold_R12: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.dataRd || stb.idxRd) |=> $stable(busRdData));
endmodule

// File: rtl/cfg_port_top.sv
module cfg_port_top
  import cfgport_pkg::*;
#(
  parameter logic [15:0] DEV_ID  = 16'h5A31,
  parameter logic [7:0]  DEV_REV = 8'h04,
  parameter logic [15:0] MAN_ID  = 16'h3C29,
  parameter logic [7:0]  OWN_LDN = 8'h07
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        strapAlt,
  input  logic [15:0] busAddr,
  input  logic        busWr,
  input  logic        busRd,
  input  logic [7:0]  busWrData,
  output logic [7:0]  busRdData,
  output logic [31:0] pinMuxCfg,
  output logic        ldEnable,
  output logic [15:0] ldBase,
  output logic        devWr,
  output logic        devRd,
  output logic [7:0]  devLdn,
  output logic [7:0]  devIdx,
  output logic [7:0]  devWrData,
  input  logic [7:0]  devRdData
);
  cfgStrobe_t stb;

  cfg_port_ctl #(.ADDR_W(16), .BASE_PRI(16'h002E), .BASE_ALT(16'h004E)) uCtl (
    .clk(clk), .rstN(rstN), .strapAlt(strapAlt), .busAddr(busAddr),
    .busWr(busWr), .busRd(busRd), .busWrData(busWrData), .stb(stb)
  );

  cfg_port_dp #(.DEV_ID(DEV_ID), .DEV_REV(DEV_REV), .MAN_ID(MAN_ID),
                .OWN_LDN(OWN_LDN), .MUX_N(4)) uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .busWrData(busWrData),
    .busRdData(busRdData), .pinMuxCfg(pinMuxCfg), .ldEnable(ldEnable),
    .ldBase(ldBase), .devWr(devWr), .devRd(devRd), .devLdn(devLdn),
    .devIdx(devIdx), .devWrData(devWrData), .devRdData(devRdData)
  );
endmodule

// File: tb/sim_cfg_port_top.sv
`timescale 1ns/1ps
module sim_cfg_port_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic strapAlt = 1'b0;
  logic [15:0] busAddr = '0;
  logic busWr = 1'b0;
  logic busRd = 1'b0;
  logic [7:0] busWrData = '0;
  logic [7:0] busRdData;
  logic [31:0] pinMuxCfg;
  logic ldEnable;
  logic [15:0] ldBase;
  logic devWr, devRd;
  logic [7:0] devLdn, devIdx, devWrData, devRdData;

  int vectors = 0;
  int errors = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  // device side stand-in: data depends on index and device number
  assign devRdData = devIdx ^ devLdn ^ 8'h5C;

  cfg_port_top u0 (.*);

  // reference model state
  int mState;            // 0 closed, 1 half key, 2 open
  logic [7:0] mIdx, mLdn, mBaseH, mBaseL, mRd;
  logic mEn;
  logic [7:0] mMux [4];
  logic [15:0] mPort;

  function automatic logic [7:0] muxSlot(input logic [7:0] ix);
    case (ix)
      8'h27: return 8'd0;
      8'h29: return 8'd1;
      8'h2A: return 8'd2;
      8'h2B: return 8'd3;
      default: return 8'hFF;
    endcase
  endfunction

  function automatic bit heldHere(input logic [7:0] ix);
    return (mLdn == 8'h07) && (ix == 8'h30 || ix == 8'h60 || ix == 8'h61);
  endfunction

  function automatic logic [7:0] modelRead(input logic [7:0] ix);
    if (ix >= 8'h30 && !heldHere(ix)) return ix ^ mLdn ^ 8'h5C;
    if (muxSlot(ix) != 8'hFF) return mMux[muxSlot(ix)];
    case (ix)
      8'h07: return mLdn;
      8'h20: return 8'h5A;
      8'h21: return 8'h31;
      8'h22: return 8'h04;
      8'h23: return 8'h3C;
      8'h24: return 8'h29;
      8'h30: return {7'd0, mEn};
      8'h60: return mBaseH;
      8'h61: return mBaseL;
      default: return 8'h00;
    endcase
  endfunction

  task automatic cmp(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  task automatic modelReset(input bit s);
    mState = 0; mIdx = '0; mLdn = '0; mBaseH = '0; mBaseL = '0; mRd = '0; mEn = 1'b0;
    for (int k = 0; k < 4; k++) mMux[k] = '0;
    mPort = s ? 16'h004E : 16'h002E;
  endtask

  task automatic step(input bit wr, input bit rd, input logic [15:0] a, input logic [7:0] d, input string tag);
    bit hitI, hitD, open, routed;
    busWr = wr; busRd = rd; busAddr = a; busWrData = d;
    #1;
    hitI = (a == mPort);
    hitD = (a == mPort + 16'd1);
    open = (mState == 2);
    routed = open && hitD && (mIdx >= 8'h30) && !heldHere(mIdx);
    cmp(tag, "devWr", devWr, wr && routed);
    cmp(tag, "devRd", devRd, rd && routed);
    if (routed) begin
      cmp(tag, "devIdx", devIdx, mIdx);
      cmp(tag, "devLdn", devLdn, mLdn);
      if (wr) cmp(tag, "devWrData", devWrData, d);
    end
    // predict the state after this edge
    if (rd && hitD) mRd = open ? modelRead(mIdx) : 8'hFF;
    else if (rd && hitI) mRd = open ? mIdx : 8'hFF;
    if (wr && hitI) begin
      if (open) begin
        if (d == 8'hAA) mState = 0; else mIdx = d;
      end else if (d == 8'h87) mState = (mState == 1) ? 2 : 1;
      else mState = 0;
    end else if (wr && hitD && open) begin
      if (muxSlot(mIdx) != 8'hFF) mMux[muxSlot(mIdx)] = d;
      else if (mIdx == 8'h07) mLdn = d;
      else if (heldHere(mIdx)) begin
        if (mIdx == 8'h30) mEn = d[0];
        else if (mIdx == 8'h60) mBaseH = d;
        else mBaseL = d;
      end
    end
    @(posedge clk); #1;
    cmp(tag, "busRdData", busRdData, mRd);
    cmp(tag, "pinMuxCfg", pinMuxCfg, {mMux[3], mMux[2], mMux[1], mMux[0]});
    cmp(tag, "ldEnable", ldEnable, mEn);
    cmp(tag, "ldBase", ldBase, {mBaseH, mBaseL});
    @(negedge clk);
    busWr = 1'b0; busRd = 1'b0;
  endtask

  task automatic doReset(input bit s);
    @(negedge clk);
    rstN = 1'b0; strapAlt = s;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    modelReset(s);
  endtask

  task automatic wIdx(input logic [15:0] p, input logic [7:0] v, input string tag);
    step(1'b1, 1'b0, p, v, tag);
  endtask
  task automatic wDat(input logic [15:0] p, input logic [7:0] v, input string tag);
    step(1'b1, 1'b0, p + 16'd1, v, tag);
  endtask
  task automatic rDat(input logic [15:0] p, input string tag);
    step(1'b0, 1'b1, p + 16'd1, 8'h00, tag);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    modelReset(1'b0);
    doReset(1'b0);
    step(1'b0, 1'b0, 16'h0000, 8'h00, "R12 reset");
    // closed: writes ignored, reads all ones
    wIdx(16'h002E, 8'h27, "R4 closed index");
    wDat(16'h002E, 8'h66, "R4 closed write");
    rDat(16'h002E, "R4 closed data read");
    step(1'b0, 1'b1, 16'h002E, 8'h00, "R4 closed index read");
    // broken key
    wIdx(16'h002E, 8'h87, "R2 first key");
    wIdx(16'h002E, 8'h55, "R2 stray value");
    wIdx(16'h002E, 8'h87, "R2 lone key");
    rDat(16'h002E, "R2 still closed");
    // proper key
    wIdx(16'h002E, 8'h87, "R1 second key");
    rDat(16'h002E, "R1 open no index");
    // identification
    for (int i = 0; i < 5; i++) begin
      wIdx(16'h002E, 8'h20 + 8'(i), "R6 select id");
      rDat(16'h002E, "R6 id byte");
    end
    wIdx(16'h002E, 8'h22, "R6 select rev");
    wDat(16'h002E, 8'hEE, "R6 write ignored");
    rDat(16'h002E, "R6 rev unchanged");
    // pin mux bytes
    wIdx(16'h002E, 8'h27, "R8"); wDat(16'h002E, 8'hA5, "R8 byte0");
    wIdx(16'h002E, 8'h29, "R8"); wDat(16'h002E, 8'h3C, "R8 byte1");
    wIdx(16'h002E, 8'h2A, "R8"); wDat(16'h002E, 8'h0F, "R8 byte2");
    wIdx(16'h002E, 8'h2B, "R8"); wDat(16'h002E, 8'hF0, "R8 byte3");
    rDat(16'h002E, "R8 readback");
    wIdx(16'h002E, 8'h29, "R8"); rDat(16'h002E, "R8 readback byte1");
    // logical device number
    wIdx(16'h002E, 8'h07, "R7"); wDat(16'h002E, 8'h07, "R7 ldn write");
    step(1'b0, 1'b1, 16'h002E, 8'h00, "R7 index read");
    rDat(16'h002E, "R7 ldn read");
    // held device registers
    wIdx(16'h002E, 8'h30, "R9"); wDat(16'h002E, 8'hFF, "R9 activate");
    rDat(16'h002E, "R9 act readback");
    wIdx(16'h002E, 8'h60, "R9"); wDat(16'h002E, 8'h12, "R9 base high");
    wIdx(16'h002E, 8'h61, "R9"); wDat(16'h002E, 8'h34, "R9 base low");
    rDat(16'h002E, "R9 base readback");
    // routed registers
    wIdx(16'h002E, 8'h31, "R10"); wDat(16'h002E, 8'h77, "R10 dev write");
    rDat(16'h002E, "R10 dev read");
    wIdx(16'h002E, 8'h07, "R10"); wDat(16'h002E, 8'h03, "R10 other ldn");
    wIdx(16'h002E, 8'h30, "R10"); wDat(16'h002E, 8'h00, "R10 act routed");
    rDat(16'h002E, "R10 act routed read");
    // unassigned low register
    wIdx(16'h002E, 8'h10, "R11"); wDat(16'h002E, 8'h99, "R11 write ignored");
    rDat(16'h002E, "R11 reads zero");
    // foreign address
    wIdx(16'h004E, 8'hAA, "R5 foreign index");
    step(1'b1, 1'b0, 16'h004F, 8'h44, "R5 foreign data");
    wIdx(16'h002E, 8'h27, "R5"); rDat(16'h002E, "R5 still open");
    // closing
    wIdx(16'h002E, 8'hAA, "R3 close");
    wDat(16'h002E, 8'h11, "R3 closed write");
    rDat(16'h002E, "R3 closed read");
    step(1'b0, 1'b0, 16'h0000, 8'h00, "R12 hold");
    // alternate base
    doReset(1'b1);
    step(1'b0, 1'b0, 16'h0000, 8'h00, "R12 reset again");
    wIdx(16'h002E, 8'h87, "R5 old base"); wIdx(16'h002E, 8'h87, "R5 old base");
    rDat(16'h002E, "R5 old base ignored");
    wIdx(16'h004E, 8'h87, "R5 alt key"); wIdx(16'h004E, 8'h87, "R5 alt key");
    wIdx(16'h004E, 8'h23, "R5 alt"); rDat(16'h004E, "R5 alt id read");
    step(1'b0, 1'b0, 16'h0000, 8'h00, "R12 final");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule